// File: doc/BRIEF.md
# Indexed Host Register Interface

This block sits between a host and a display controller's settings. The host uses one 16-bit port that has a command/data select. A command-phase write sets an 8-bit register pointer. Data-phase reads and writes then reach the register the pointer names. After each data access the pointer moves on by two, so a run of registers can be filled without new commands. The exceptions are the three streaming ports, where the pointer stays put so that repeated accesses feed one port.

The registers behind the port include the following:
- split coordinate and refresh values, written one byte at a time;
- registers whose writes pass through a mask;
- a divider register stored with an offset of one;
- a sticky interrupt flag register that sets from hardware events and clears by an AND write;
- two tables reached through an index that advances after each access. The coefficient table has 32 entries and saturates its index. The gamma table has 256 entries and its index wraps.

A fixed number of the first accesses after reset are swallowed. This lets a host's start-up dummy cycles pass without effect.

The host side is a valid/ready request channel plus a valid/ready read-response channel. Words written to the display-data port leave on a valid/ready pixel stream. The block accepts at most one request while nothing is outstanding. `req_ready` is low while a read response waits for `rsp_ready`, and low while a pixel word waits for `pix_ready`. Once raised, `rsp_valid` and `pix_valid` hold with stable data until their ready is seen high at a clock edge.

Top module: `hri_regif`

## Requirements
- R1: After reset, reads return these values:
  - refresh low (0x18) 0x5C and refresh high (0x1A) 0x02;
  - panel setup (0x28) 0x74;
  - serial transmit mode (0x42) 0x01;
  - coefficient setup (0x56) 0x80;
  - pull-down (0xF8) 0xFF;
  - divider (0x04) 0x80;
  - every other register 0.

  The pointer starts at 0, and `irq`, `rsp_valid` and `pix_valid` are low.
- R2: The first SKIP_COUNT accepted requests (default 2) change nothing. A swallowed read still returns a response, with data 0.
- R3: A command-phase write loads the pointer from `req_data[7:0]`. A command-phase read returns the pointer in bits 7:0.
- R4: After each data-phase access the pointer becomes pointer+2 modulo 256. It does not move at 0x90 (display data), 0x5A (coefficient data) or 0xB8 (gamma data).
- R5: Eight 10-bit window coordinates are split across register pairs:
  - coordinate k has its low register at 0x6C+4k, holding bits 7:0;
  - its high register at 0x6E+4k takes bits 9:8 from `req_data[1:0]` and reads back value>>8.

  The 12-bit refresh interval works the same way. Its low byte is at 0x18, and 0x1A takes bits 11:8 from `req_data[3:0]`.
- R6: Masked registers store the write data ANDed with a fixed mask:
  - 0x28 with 0xFF;
  - 0x42 with 0xBD;
  - 0x56 with 0xBF;
  - 0x68 with 0xB7;
  - 0xB4 with 0x87;
  - 0xE6 with 0x83;
  - 0xF8 with 0xFF.
- R7: A write of v to 0x04 stores (v&0x3F)+1. A read returns (stored−1) with bit 7 set.
- R8: A write to 0x58 sets the coefficient index to v&0x1F, and 0x58 reads back the index.
  - An access to 0x5A while the index is below 32 reads or writes that entry and then adds one to the index.
  - At index 32 an access to 0x5A reads 0, writes nothing, and the index holds.
- R9: 0xB6 sets and returns the 8-bit gamma index. An access to 0xB8 reads or writes that entry, then adds one to the index, wrapping 255 to 0.
- R10: A pending flag at 0xF6 sets on any cycle its `gpio_event` bit is high. A write of v to 0xF6 ANDs v into the flags, and an event in the same cycle wins. `irq` is high one cycle after any flag is set.
- R11: Addresses not named above read 0 and ignore writes. This includes all odd addresses and 0x90 on read.
- R12: `req_ready` is low while `rsp_valid` or `pix_valid` is high. A read response appears the cycle after the request is accepted. It holds with stable data until `rsp_ready`.
- R13: A data write to 0x90 puts the full 16-bit word on `pix_data` with `pix_valid` the next cycle. The word holds until `pix_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_cmd | input | 1 | 1 = command phase, 0 = data phase |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 16 | Write data or command byte |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 16 | Read data, bits 15:8 zero |
| pix_valid | output | 1 | Display-data word present |
| pix_ready | input | 1 | Downstream takes display word |
| pix_data | output | 16 | Display-data word |
| gpio_event | input | 8 | Per-bit interrupt event pulses |
| irq | output | 1 | Any interrupt flag pending |

## Verification
The hardest state to reach is the coefficient index sitting at 32, where the data port must go inert. Random traffic rarely walks the index that far without a new command moving the pointer away. Directed steps therefore load the index near the top and stream across the limit before reading the index back. A reference model tracks the pointer, the swallow count, both indices and both tables through random mixes of command and data accesses. Every read is compared with that model, so a wrong pointer step shows up as a wrong value on a later read.

// File: rtl/hri_pkg.sv
package hri_pkg;
  localparam logic [7:0] ADR_PLL    = 8'h04;
  localparam logic [7:0] ADR_RFL    = 8'h18;
  localparam logic [7:0] ADR_RFH    = 8'h1A;
  localparam logic [7:0] ADR_FIDX   = 8'h58;
  localparam logic [7:0] ADR_FDAT   = 8'h5A;
  localparam logic [7:0] ADR_PIX    = 8'h90;
  localparam logic [7:0] ADR_GIDX   = 8'hB6;
  localparam logic [7:0] ADR_GDAT   = 8'hB8;
  localparam logic [7:0] ADR_IRQ    = 8'hF6;
  localparam logic [7:0] WIN_BASE   = 8'h6C;
  localparam int         NUM_COORD  = 8;
  localparam int         COORD_W    = 10;
  localparam int         NUM_SIMPLE = 7;
  localparam int         RFR_W      = 12;
  localparam logic [RFR_W-1:0] RFR_RESET = 12'h25C;

  function automatic logic [7:0] simple_addr(input int i);
    case (i)
      0: return 8'h28;
      1: return 8'h42;
      2: return 8'h56;
      3: return 8'h68;
      4: return 8'hB4;
      5: return 8'hE6;
      default: return 8'hF8;
    endcase
  endfunction

  function automatic logic [7:0] simple_mask(input int i);
    case (i)
      0: return 8'hFF;
      1: return 8'hBD;
      2: return 8'hBF;
      3: return 8'hB7;
      4: return 8'h87;
      5: return 8'h83;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] simple_reset(input int i);
    case (i)
      0: return 8'h74;
      1: return 8'h01;
      2: return 8'h80;
      6: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_stream(input logic [7:0] a);
    return (a == ADR_PIX) || (a == ADR_FDAT) || (a == ADR_GDAT);
  endfunction

  function automatic logic in_window(input logic [7:0] a);
    return (a >= WIN_BASE) && (a <= WIN_BASE + 8'(4 * NUM_COORD - 2)) && !a[0];
  endfunction
endpackage

// File: rtl/hri_seq.sv
module hri_seq #(
  parameter int SKIP_COUNT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       is_cmd,
  input  logic       is_wr,
  input  logic [7:0] wbyte,
  output logic       live,
  output logic [7:0] addr
);
  localparam int CW = $clog2(SKIP_COUNT + 2);

  logic [CW-1:0] skip_q;

  assign live = acc && (skip_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q <= CW'(SKIP_COUNT);
    end else if (acc && skip_q != '0) begin
      skip_q <= skip_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= 8'h00;
    end else if (live && is_cmd && is_wr) begin
      addr <= wbyte;
    end else if (live && !is_cmd && !hri_pkg::is_stream(addr)) begin
      addr <= addr + 8'd2;
    end
  end
endmodule

// File: rtl/hri_itable.sv
module hri_itable #(
  parameter int DEPTH    = 32,
  parameter bit SATURATE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_acc,
  input  logic       data_wr,
  input  logic [7:0] wbyte,
  output logic [7:0] idx_rd,
  output logic [7:0] data_rd
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = SATURATE ? AW + 1 : AW;

  logic [IW-1:0] idx;
  logic [AW-1:0] slot;
  logic          in_range;
  logic [7:0]    mem [DEPTH];

  generate
    if (SATURATE) begin : g_sat
      assign in_range = (idx < IW'(DEPTH));
    end else begin : g_wrap
      assign in_range = 1'b1;
    end
  endgenerate

  assign slot = idx[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_wr) begin
      idx <= IW'(wbyte[AW-1:0]);
    end else if (data_acc && in_range) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (data_acc && data_wr && in_range) begin
      mem[slot] <= wbyte;
    end
  end

  assign idx_rd  = 8'(idx);
  assign data_rd = in_range ? mem[slot] : 8'h00;
endmodule

// File: rtl/hri_coord_bank.sv
module hri_coord_bank #(
  parameter int         NUM  = 8,
  parameter int         W    = 10,
  parameter logic [7:0] BASE = 8'h6C
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [7:0]     addr,
  input  logic [7:0]     wbyte,
  output logic [NUM*W-1:0] coords
);
  generate
    for (genvar k = 0; k < NUM; k++) begin : g_coord
      localparam logic [7:0] LO = BASE + 8'(4 * k);
      localparam logic [7:0] HI = LO + 8'd2;
      logic [W-1:0] val;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          val <= '0;
        end else if (wr && addr == LO) begin
          val[7:0] <= wbyte;
        end else if (wr && addr == HI) begin
          val[W-1:8] <= wbyte[W-9:0];
        end
      end
      assign coords[k*W +: W] = val;
    end
  endgenerate
endmodule

// File: rtl/hri_regif.sv
module hri_regif #(
  parameter int SKIP_COUNT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_cmd,
  input  logic        req_write,
  input  logic [15:0] req_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_data,
  output logic        pix_valid,
  input  logic        pix_ready,
  output logic [15:0] pix_data,
  input  logic [7:0]  gpio_event,
  output logic        irq
);
  import hri_pkg::*;

  localparam int KW = $clog2(NUM_COORD);

  logic       acc, live, dwr, dacc;
  logic [7:0] addr, wbyte, rd_byte;
  logic [7:0] fidx_rd, fdat_rd, gidx_rd, gdat_rd;
  logic [NUM_COORD*COORD_W-1:0] coords;
  logic [COORD_W-1:0] win_val;
  logic [KW-1:0]      win_k;
  logic [7:0]         win_off;
  logic [6:0]         pll_q;
  logic [RFR_W-1:0]   rfr_q;
  logic [7:0]         irq_q;
  logic [7:0]         simple_q [NUM_SIMPLE];

  assign req_ready = !rsp_valid && !pix_valid;
  assign acc       = req_valid && req_ready;
  assign wbyte     = req_data[7:0];
  assign dacc      = live && !req_cmd;
  assign dwr       = dacc && req_write;

  hri_seq #(.SKIP_COUNT(SKIP_COUNT)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .is_cmd(req_cmd),
    .is_wr(req_write), .wbyte(wbyte), .live(live), .addr(addr)
  );

  hri_itable #(.DEPTH(32), .SATURATE(1'b1)) u_coef (
    .clk(clk), .rst_n(rst_n),
    .idx_wr(dwr && addr == ADR_FIDX),
    .data_acc(dacc && addr == ADR_FDAT),
    .data_wr(req_write), .wbyte(wbyte),
    .idx_rd(fidx_rd), .data_rd(fdat_rd)
  );

  hri_itable #(.DEPTH(256), .SATURATE(1'b0)) u_gamma (
    .clk(clk), .rst_n(rst_n),
    .idx_wr(dwr && addr == ADR_GIDX),
    .data_acc(dacc && addr == ADR_GDAT),
    .data_wr(req_write), .wbyte(wbyte),
    .idx_rd(gidx_rd), .data_rd(gdat_rd)
  );

  hri_coord_bank #(.NUM(NUM_COORD), .W(COORD_W), .BASE(WIN_BASE)) u_win (
    .clk(clk), .rst_n(rst_n), .wr(dwr), .addr(addr), .wbyte(wbyte),
    .coords(coords)
  );

  // masked plain registers
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SIMPLE; i++) begin
      if (!rst_n) begin
        simple_q[i] <= simple_reset(i);
      end else if (dwr && addr == simple_addr(i)) begin
        simple_q[i] <= wbyte & simple_mask(i);
      end
    end
  end

  // divider with offset-of-one storage, refresh interval split in two
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_q <= 7'd1;
      rfr_q <= RFR_RESET;
    end else if (dwr) begin
      if (addr == ADR_PLL) pll_q <= {1'b0, wbyte[5:0]} + 7'd1;
      if (addr == ADR_RFL) rfr_q[7:0] <= wbyte;
      if (addr == ADR_RFH) rfr_q[RFR_W-1:8] <= wbyte[RFR_W-9:0];
    end
  end

  // sticky event flags, cleared by AND write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 8'h00;
    end else begin
      irq_q <= ((dwr && addr == ADR_IRQ) ? (irq_q & wbyte) : irq_q) | gpio_event;
    end
  end
  assign irq = |irq_q;

  assign win_off = addr - WIN_BASE;
  assign win_k   = win_off[KW+1:2];
  assign win_val = coords[win_k*COORD_W +: COORD_W];

  always_comb begin
    rd_byte = 8'h00;
    if (in_window(addr)) begin
      rd_byte = addr[1] ? 8'(win_val >> 8) : win_val[7:0];
    end else begin
      case (addr)
        ADR_PLL:  rd_byte = {1'b1, 7'(pll_q - 7'd1)};
        ADR_RFL:  rd_byte = rfr_q[7:0];
        ADR_RFH:  rd_byte = 8'(rfr_q >> 8);
        ADR_FIDX: rd_byte = fidx_rd;
        ADR_FDAT: rd_byte = fdat_rd;
        ADR_GIDX: rd_byte = gidx_rd;
        ADR_GDAT: rd_byte = gdat_rd;
        ADR_IRQ:  rd_byte = irq_q;
        default:  rd_byte = 8'h00;
      endcase
      for (int i = 0; i < NUM_SIMPLE; i++) begin
        if (addr == simple_addr(i)) rd_byte = simple_q[i];
      end
    end
  end

  // read response channel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 16'h0000;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      if (!live)        rsp_data <= 16'h0000;
      else if (req_cmd) rsp_data <= {8'h00, addr};
      else              rsp_data <= {8'h00, rd_byte};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // display-data stream
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_data  <= 16'h0000;
    end else if (dwr && addr == ADR_PIX) begin
      pix_valid <= 1'b1;
      pix_data  <= req_data;
    end else if (pix_ready) begin
      pix_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hri_regif_checker.sv
module hri_regif_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_cmd,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [15:0] pix_data,
  input logic [7:0]  gpio_event,
  input logic        irq
);
  assert_ready_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || pix_valid) |-> !req_ready);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_rsp_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));

  assert_pix_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

  assert_pix_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> $past(req_valid && req_ready && req_write && !req_cmd));

  assert_event_sets_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_event != 8'h00) |=> irq);
endmodule

bind hri_regif hri_regif_checker u_chk (.*);

// File: tb/hri_regif_test.sv
module hri_regif_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_cmd = 1'b0, req_write = 1'b0;
  logic [15:0] req_data = 16'h0;
  logic        rsp_ready = 1'b0, pix_ready = 1'b0;
  logic [7:0]  gpio_event = 8'h0;
  logic        req_ready, rsp_valid, pix_valid, irq;
  logic [15:0] rsp_data, pix_data;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  hri_regif uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_write(req_write), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .gpio_event(gpio_event), .irq(irq)
  );

  // reference model state
  logic [7:0]  maddr;
  int          mskip;
  logic [6:0]  mpll;
  logic [11:0] mref;
  logic [9:0]  mco [8];
  logic [7:0]  msimp [256];
  logic [7:0]  mfilt [32];
  logic [5:0]  fidx;
  logic [7:0]  mgam [256];
  logic [7:0]  gidx;
  logic [7:0]  mirq;

  function automatic logic [7:0] smask(input logic [7:0] a);
    case (a)
      8'h28, 8'hF8: return 8'hFF;
      8'h42: return 8'hBD;
      8'h56: return 8'hBF;
      8'h68: return 8'hB7;
      8'hB4: return 8'h87;
      8'hE6: return 8'h83;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit is_simple(input logic [7:0] a);
    return a inside {8'h28, 8'h42, 8'h56, 8'h68, 8'hB4, 8'hE6, 8'hF8};
  endfunction

  function automatic bit is_win(input logic [7:0] a);
    return a >= 8'h6C && a <= 8'h8A && !a[0];
  endfunction

  function automatic bit is_str(input logic [7:0] a);
    return a == 8'h90 || a == 8'h5A || a == 8'hB8;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h04) return "R7";
    if (a == 8'h18 || a == 8'h1A || is_win(a)) return "R5";
    if (a == 8'h58 || a == 8'h5A) return "R8";
    if (a == 8'hB6 || a == 8'hB8) return "R9";
    if (a == 8'hF6) return "R10";
    if (is_simple(a)) return "R6";
    return "R11";
  endfunction

  task automatic m_init();
    maddr = 8'h00; mskip = 2; mpll = 7'd1; mref = 12'h25C;
    for (int i = 0; i < 8; i++) mco[i] = 10'h0;
    for (int i = 0; i < 256; i++) msimp[i] = 8'h00;
    msimp[8'h28] = 8'h74; msimp[8'h42] = 8'h01; msimp[8'h56] = 8'h80; msimp[8'hF8] = 8'hFF;
    fidx = 6'd0; gidx = 8'd0; mirq = 8'h00;
  endtask

  task automatic m_write(input logic [7:0] a, input logic [7:0] v);
    if (is_win(a)) begin
      if (a[1]) mco[(a - 8'h6C) >> 2][9:8] = v[1:0];
      else      mco[(a - 8'h6C) >> 2][7:0] = v;
    end else if (is_simple(a)) msimp[a] = v & smask(a);
    else case (a)
      8'h04: mpll = {1'b0, v[5:0]} + 7'd1;
      8'h18: mref[7:0] = v;
      8'h1A: mref[11:8] = v[3:0];
      8'h58: fidx = {1'b0, v[4:0]};
      8'h5A: if (fidx < 6'd32) begin mfilt[fidx[4:0]] = v; fidx = fidx + 6'd1; end
      8'hB6: gidx = v;
      8'hB8: begin mgam[gidx] = v; gidx = gidx + 8'd1; end
      8'hF6: mirq = mirq & v;
      default: ;
    endcase
  endtask

  task automatic m_read(input logic [7:0] a, output logic [7:0] v);
    v = 8'h00;
    if (is_win(a)) begin
      v = a[1] ? {6'b0, mco[(a - 8'h6C) >> 2][9:8]} : mco[(a - 8'h6C) >> 2][7:0];
    end else if (is_simple(a)) v = msimp[a];
    else case (a)
      8'h04: v = {1'b1, 7'(mpll - 7'd1)};
      8'h18: v = mref[7:0];
      8'h1A: v = {4'h0, mref[11:8]};
      8'h58: v = {2'b00, fidx};
      8'h5A: if (fidx < 6'd32) begin v = mfilt[fidx[4:0]]; fidx = fidx + 6'd1; end
      8'hB6: v = gidx;
      8'hB8: begin v = mgam[gidx]; gidx = gidx + 8'd1; end
      8'hF6: v = mirq;
      default: v = 8'h00;
    endcase
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one host access, predicted by the model and compared at the ports
  task automatic step(input bit cmd, input bit wr, input logic [15:0] d,
                      input string tag_in, input int hold);
    logic [15:0] exp;
    logic [15:0] got;
    logic [7:0]  rb;
    bit          pixel;
    string       tag;
    exp = 16'h0; pixel = 1'b0; rb = 8'h0;
    tag = tag_in;
    if (tag == "") tag = (mskip > 0) ? "R2" : cmd ? "R3" : tag_of(maddr);
    if (mskip > 0) mskip--;
    else if (cmd) begin
      if (wr) maddr = d[7:0]; else exp = {8'h00, maddr};
    end else begin
      if (wr) begin pixel = (maddr == 8'h90); m_write(maddr, d[7:0]); end
      else begin m_read(maddr, rb); exp = {8'h00, rb}; end
      if (!is_str(maddr)) maddr = maddr + 8'd2;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_write = wr; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      got = rsp_data;
      if (hold > 0) begin
        repeat (hold) @(negedge clk);
        check(rsp_valid && !req_ready && rsp_data == got, "R12", rsp_data, got);
      end
      check(got == exp, tag, got, exp);
      rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    end else if (pixel) begin
      check(pix_valid && pix_data == d && !req_ready, "R13", pix_data, d);
      if (hold > 0) begin
        repeat (hold) @(negedge clk);
        check(pix_valid && pix_data == d, "R13", pix_data, d);
      end
      pix_ready = 1'b1; @(negedge clk); pix_ready = 1'b0;
    end
  endtask

  task automatic rd_at(input logic [7:0] a, input string tag);
    step(1'b1, 1'b1, {8'h00, a}, tag, 0);
    step(1'b0, 1'b0, 16'h0, tag, 0);
  endtask

  task automatic wr_at(input logic [7:0] a, input logic [7:0] v);
    step(1'b1, 1'b1, {8'h00, a}, "", 0);
    step(1'b0, 1'b1, {8'h00, v}, "", 0);
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned r);
    case (r % 20)
      0: return 8'h04;  1: return 8'h18;  2: return 8'h1A;  3: return 8'h28;
      4: return 8'h42;  5: return 8'h56;  6: return 8'h58;  7: return 8'h5A;
      8: return 8'h68;  9: return 8'h90; 10: return 8'hB4; 11: return 8'hB6;
      12: return 8'hB8; 13: return 8'hE6; 14: return 8'hF6; 15: return 8'hF8;
      16: return 8'h33; 17: return 8'h30;
      default: return 8'h6C + 8'(2 * ((r >> 5) % 16));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    m_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle outputs after reset
    check(req_ready && !rsp_valid && !pix_valid && !irq, "R1",
          {12'h0, req_ready, rsp_valid, pix_valid, irq}, 16'h8);

    // R2 the first two accesses are swallowed
    step(1'b1, 1'b1, 16'h0004, "R2", 0);
    step(1'b0, 1'b0, 16'h0000, "R2", 0);
    rd_at(8'h00, "R3");

    // R1 reset values
    rd_at(8'h18, "R1"); rd_at(8'h1A, "R1"); rd_at(8'h28, "R1");
    rd_at(8'h42, "R1"); rd_at(8'h56, "R1"); rd_at(8'hF8, "R1");
    rd_at(8'h04, "R1"); rd_at(8'h68, "R1"); rd_at(8'h6E, "R1");

    // R3 command read returns pointer
    step(1'b1, 1'b1, 16'hAB42, "R3", 0);
    step(1'b1, 1'b0, 16'h0, "R3", 0);

    // R4 pointer advances across a coordinate run, then wraps
    step(1'b1, 1'b1, 16'h006C, "R4", 0);
    step(1'b0, 1'b1, 16'h00A5, "R4", 0);
    step(1'b0, 1'b1, 16'h00FF, "R4", 0);
    step(1'b0, 1'b1, 16'h003C, "R4", 0);
    rd_at(8'h6C, "R4");
    step(1'b0, 1'b0, 16'h0, "R5", 0);
    step(1'b0, 1'b0, 16'h0, "R4", 0);
    step(1'b1, 1'b1, 16'h00FE, "R4", 0);
    step(1'b0, 1'b0, 16'h0, "R4", 0);
    step(1'b1, 1'b0, 16'h0, "R4", 0);

    // R5 refresh split, R6 masks, R7 divider
    wr_at(8'h1A, 8'hF7); rd_at(8'h1A, "R5"); rd_at(8'h18, "R5");
    wr_at(8'h68, 8'hFF); rd_at(8'h68, "R6");
    wr_at(8'hE6, 8'hFF); rd_at(8'hE6, "R6");
    wr_at(8'h04, 8'hFF); rd_at(8'h04, "R7");
    wr_at(8'h04, 8'h00); rd_at(8'h04, "R7");

    // R8 and R9 fill both tables through their streaming ports
    wr_at(8'h58, 8'h00);
    for (int i = 0; i < 32; i++) step(1'b0, 1'b1, 16'(8'(i * 7 + 3)), "R8", 0);
    wr_at(8'hB6, 8'h00);
    for (int i = 0; i < 256; i++) step(1'b0, 1'b1, 16'(8'(i * 13 + 1)), "R9", 0);
    rd_at(8'hB6, "R9");
    // R8 saturation at 32
    wr_at(8'h58, 8'h3E);
    rd_at(8'h58, "R8");
    step(1'b0, 1'b1, 16'h0011, "R8", 0);
    step(1'b0, 1'b1, 16'h0022, "R8", 0);
    step(1'b0, 1'b1, 16'h0033, "R8", 0);
    step(1'b0, 1'b0, 16'h0, "R8", 0);
    rd_at(8'h58, "R8");
    wr_at(8'h58, 8'h1E);
    step(1'b0, 1'b0, 16'h0, "R8", 0);
    step(1'b0, 1'b0, 16'h0, "R8", 0);
    // R9 wrap 255 -> 0
    wr_at(8'hB6, 8'hFF);
    step(1'b0, 1'b0, 16'h0, "R9", 0);
    step(1'b0, 1'b0, 16'h0, "R9", 0);
    rd_at(8'hB6, "R9");

    // R10 event flags
    @(negedge clk); gpio_event = 8'h5A; @(negedge clk); gpio_event = 8'h00;
    mirq = 8'h5A;
    check(irq == 1'b1, "R10", {15'h0, irq}, 16'h1);
    rd_at(8'hF6, "R10");
    wr_at(8'hF6, 8'h0F); rd_at(8'hF6, "R10");
    wr_at(8'hF6, 8'h00);
    @(negedge clk);
    check(irq == 1'b0, "R10", {15'h0, irq}, 16'h0);

    // R11 unknown addresses
    wr_at(8'h31, 8'hFF); rd_at(8'h31, "R11");
    wr_at(8'h2A, 8'h55); rd_at(8'h2A, "R11");
    rd_at(8'h90, "R11");

    // R12 and R13 back-pressure
    step(1'b1, 1'b1, 16'h0028, "R12", 0);
    step(1'b0, 1'b0, 16'h0, "R12", 4);
    step(1'b1, 1'b1, 16'h0090, "R13", 0);
    step(1'b0, 1'b1, 16'hBEEF, "R13", 3);
    step(1'b0, 1'b1, 16'h1234, "R13", 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      r = $urandom;
      if (r % 4 == 0) step(1'b1, 1'b1, {8'($urandom), pick_addr($urandom)}, "", 0);
      else if (r % 4 == 1) step(1'b0, 1'b1, 16'($urandom), "", 0);
      else step(1'b0, 1'b0, 16'h0, "", 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule